// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a synchronous serial slave that gives a host access to a bank of sixteen 8-bit control register slots. The host lowers an active-low frame select, then clocks in a command byte. It may follow that with one data byte. Every bit goes most-significant first, on a shift clock that idles low. The command byte always carries the power-state bit. It can also ask for a register write, a register read, or nothing more. For a read, the selected register is returned on a serial output that changes on falling shift-clock edges, so the host samples it on the next rising edge.

All serial inputs are brought into the system clock domain by a synchronizer and edge detector. The shift clock therefore has to be slow relative to the system clock. The serial link has no back-pressure: every bit the host clocks is taken, and a frame is never stalled. The register contents and the power-down flag are plain level outputs for the logic they control.

Top module: `scr_serial_regs`

## Requirements
- R1: A command byte is the first 8 bits of a frame, sampled on rising shift-clock edges, MSB first. Bit 7 is the power bit, bits 6..3 the register address, bit 2 the direction (0 = write, 1 = read), bit 1 the data-follows flag, and bit 0 is reserved and ignored.
- R2: When the eighth command bit is received, `pwr_down` takes the value of the power bit (1 = powered down). This happens on every frame, single-byte or not.
- R3: A command with the data-follows flag at 0 accesses no register. Any further bits in that frame are ignored, and no slot changes.
- R4: A write (direction 0, data-follows 1) stores the 8 data bits, MSB first, into the addressed slot when the eighth data bit is received. The slot appears on `ctrl_regs[8*a +: 8]`. A write changes no other slot.
- R5: For a read (direction 1, data-follows 1), `sdo` presents the addressed slot MSB first. The first bit appears on the falling edge that follows the eighth command bit, and each later falling edge gives the next bit. Whenever no read bit is being presented, including while the frame select is high, `sdo` is 0.
- R6: Addresses 12, 13 and 15 hold no storage. Writes to them are ignored, their `ctrl_regs` slices stay 0, and reads from them return 0.
- R7: Slots can be written and read while powered down, and they keep their contents across power-down and power-up.
- R8: While `rst_n` is low, all slots and `pwr_down` are 0 and `sdo` is 0.
- R9: Writing a byte with bit 7 set to address 10 clears every slot to 0, including slot 10 itself, so the bit reads back as 0. `pwr_down` is not affected. A write to address 10 with bit 7 clear stores the byte normally.
- R10: Raising the frame select before a byte is complete discards that byte. A partial command byte does not change `pwr_down`, and a partial data byte writes nothing.
- R11: Address 14 is ordinary read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial shift clock, idles low |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data out, 0 when idle |
| pwr_down | output | 1 | Power-down flag, 1 = powered down |
| ctrl_regs | output | 128 | All register slots, slot a at bits 8*a+7..8*a |

## Verification
A bit counter that is off by one would show as a byte landing in the wrong slot or with shifted bits. It would be visible on `ctrl_regs` right after the frame, and on `sdo` within the next read frame. A wrong read-path state shows as data appearing one shift-clock edge early or late, or as `sdo` staying high after the eighth read bit. A power flag latched at the wrong moment is visible on `pwr_down` within the same frame, and a leaky discard path shows as a slot changed by a frame that was cut short.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int BANK_W   = NUM_REGS * DATA_W;
  localparam int CNT_W    = $clog2(DATA_W);

  // slots that hold storage; addresses 12, 13 and 15 are holes
  localparam logic [NUM_REGS-1:0] PRESENT_MASK = 16'b0100_1111_1111_1111;

  typedef struct packed {
    logic              pwr;
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              more;
    logic              rsvd;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2
  } phase_t;

endpackage

// File: rtl/scr_sync_edge.sv
module scr_sync_edge #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;

endmodule

// File: rtl/scr_frame_ctrl.sv
module scr_frame_ctrl
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              bit_rise,
  input  logic              sdi_bit,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              cmd_done,
  output logic              rd_start,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              pwr_down
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_next;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              byte_end;
  cmd_t              cmd_now;

  assign rx_next  = {rx_sh[DATA_W-2:0], sdi_bit};
  assign cmd_now  = cmd_t'(rx_next);
  assign byte_end = frame_act && bit_rise && (bit_cnt == LAST_BIT);
  assign cmd_done = byte_end && (phase == ST_CMD);
  assign rd_start = cmd_done && cmd_now.more && cmd_now.rd;
  // during the command byte the read port follows the incoming address
  assign acc_addr = (phase == ST_CMD) ? cmd_now.addr : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= ST_CMD;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      pwr_down <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!frame_act) begin
        phase   <= ST_CMD;
        bit_cnt <= '0;
      end else begin
        unique case (phase)
          ST_CMD: if (bit_rise) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              pwr_down <= cmd_now.pwr;
              addr_q   <= cmd_now.addr;
              rd_q     <= cmd_now.rd;
              phase    <= cmd_now.more ? ST_DATA : ST_SKIP;
            end
          end
          ST_DATA: if (bit_rise) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (!rd_q) begin
                wr_en   <= 1'b1;
                wr_data <= rx_next;
              end
              phase <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/scr_tx_shift.sv
module scr_tx_shift
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_fall,
  output logic              sdo
);

  localparam int TXC_W = $clog2(DATA_W + 1);
  localparam logic [TXC_W-1:0] TX_END = TXC_W'(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [TXC_W-1:0]  cnt;
  logic              act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
      sdo <= 1'b0;
    end else if (!frame_act) begin
      cnt <= '0;
      act <= 1'b0;
      sdo <= 1'b0;
    end else if (load) begin
      sh  <= load_data;
      cnt <= '0;
      act <= 1'b1;
    end else if (act && bit_fall) begin
      if (cnt == TX_END) begin
        act <= 1'b0;
        sdo <= 1'b0;
      end else begin
        sdo <= sh[DATA_W-1];
        sh  <= {sh[DATA_W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scr_reg_bank.sv
module scr_reg_bank
  import scr_pkg::*;
#(
  parameter int CLR_ADDR = 10,
  parameter int CLR_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANK_W-1:0] bank
);

  logic [DATA_W-1:0] slot [NUM_REGS];
  logic              bank_clr;

  assign bank_clr = wr_en && (addr == ADDR_W'(CLR_ADDR)) && wr_data[CLR_BIT];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      if (PRESENT_MASK[g]) begin : g_store
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                                  slot[g] <= '0;
          else if (bank_clr)                           slot[g] <= '0;
          else if (wr_en && (addr == ADDR_W'(g)))      slot[g] <= wr_data;
        end
      end else begin : g_hole
        assign slot[g] = '0;
      end
      assign bank[g*DATA_W +: DATA_W] = slot[g];
    end
  endgenerate

  assign rd_data = slot[addr];

endmodule

// File: rtl/scr_serial_regs.sv
module scr_serial_regs
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_ADDR    = 10,
  parameter int CLR_BIT     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              sdi,
  output logic              sdo,
  output logic              pwr_down,
  output logic [BANK_W-1:0] ctrl_regs
);

  // synchronized vector: [0] shift clock, [1] frame select, [2] data in
  logic [2:0]        s_lvl, s_rise, s_fall;
  logic              csn_lvl, frame_act;
  logic [ADDR_W-1:0] acc_addr;
  logic              cmd_done, rd_start, wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  scr_sync_edge #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, csn, sclk}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign csn_lvl   = s_lvl[1];
  assign frame_act = ~csn_lvl;

  scr_frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .bit_rise(s_rise[0]), .sdi_bit(s_lvl[2]),
    .acc_addr(acc_addr), .cmd_done(cmd_done), .rd_start(rd_start),
    .wr_en(wr_en), .wr_data(wr_data), .pwr_down(pwr_down)
  );

  scr_reg_bank #(
    .CLR_ADDR(CLR_ADDR), .CLR_BIT(CLR_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(acc_addr),
    .wr_data(wr_data), .rd_data(rd_data), .bank(ctrl_regs)
  );

  scr_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
    .load(rd_start), .load_data(rd_data),
    .bit_fall(s_fall[0]), .sdo(sdo)
  );

endmodule

// File: rtl/scr_serial_regs_chk.sv
module scr_serial_regs_chk
  import scr_pkg::*;
#(
  parameter int CLR_ADDR = 10,
  parameter int CLR_BIT  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_lvl,
  input logic              sdo,
  input logic              pwr_down,
  input logic [BANK_W-1:0] ctrl_regs,
  input logic              cmd_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  logic              clr_hit;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  assign clr_hit = wr_en && (wr_addr == ADDR_W'(CLR_ADDR)) && wr_data[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pend      <= wr_en && !clr_hit && PRESENT_MASK[wr_addr];
      pend_addr <= wr_addr;
      pend_data <= wr_data;
    end
  end

  assert_idle_sdo_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csn_lvl |=> !sdo);

  assert_pwr_on_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_down) |-> $past(cmd_done));

  assert_bank_moves_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_regs) |-> $past(wr_en));

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (ctrl_regs[pend_addr*DATA_W +: DATA_W] == pend_data));

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (ctrl_regs == '0));

  assert_write_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!csn_lvl));

endmodule

bind scr_serial_regs scr_serial_regs_chk #(
  .CLR_ADDR(CLR_ADDR), .CLR_BIT(CLR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_lvl(csn_lvl), .sdo(sdo),
  .pwr_down(pwr_down), .ctrl_regs(ctrl_regs), .cmd_done(cmd_done),
  .wr_en(wr_en), .wr_addr(acc_addr), .wr_data(wr_data)
);

// File: tb/tb_scr_serial_regs.sv
`timescale 1ns/1ps
module tb_scr_serial_regs;

  localparam int HALF = 8;  // system clocks per shift-clock half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         csn = 1'b1;
  logic         sdi = 1'b0;
  logic         sdo;
  logic         pwr_down;
  logic [127:0] ctrl_regs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scr_serial_regs dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .pwr_down(pwr_down), .ctrl_regs(ctrl_regs)
  );

  function automatic logic [7:0] mk_cmd(input logic pwr, input logic [3:0] a,
                                        input logic rd, input logic more);
    return {pwr, a, rd, more, 1'b0};
  endfunction

  function automatic logic [7:0] slot(input int a);
    return ctrl_regs[a*8 +: 8];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clocks nbits of {cmd,data} MSB first; captures sdo before each data-bit rise
  task automatic frame(input logic [7:0] cmd, input logic [7:0] data,
                       input int nbits, output logic [7:0] rx);
    logic [15:0] word;
    word = {cmd, data};
    rx = 8'h00;
    @(negedge clk);
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = word[15-i];
      wait_clk(HALF);
      if (i >= 8) rx[15-i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    sdi = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic wr(input logic pwr, input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rx;
    frame(mk_cmd(pwr, a, 1'b0, 1'b1), d, 16, rx);
  endtask

  task automatic rd(input logic pwr, input logic [3:0] a, output logic [7:0] d);
    frame(mk_cmd(pwr, a, 1'b1, 1'b1), 8'h00, 16, d);
  endtask

  task automatic t_reset;
    logic bad;
    bad = 1'b0;
    for (int a = 0; a < 16; a++) if (slot(a) !== 8'h00) bad = 1'b1;
    chk("R8", "bank nonzero after reset", {7'd0, bad}, 8'h00);
    chk("R8", "pwr_down after reset", {7'd0, pwr_down}, 8'h00);
    chk("R8", "sdo after reset", {7'd0, sdo}, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] r;
    wr(1'b0, 4'd3, 8'hA5);
    chk("R4", "slot3 after write", slot(3), 8'hA5);
    wr(1'b0, 4'd0, 8'h3C);
    wr(1'b0, 4'd9, 8'h81);
    chk("R4", "slot0", slot(0), 8'h3C);
    chk("R4", "slot9", slot(9), 8'h81);
    chk("R4", "slot3 untouched", slot(3), 8'hA5);
    rd(1'b0, 4'd3, r);
    chk("R5", "read slot3", r, 8'hA5);
    rd(1'b0, 4'd9, r);
    chk("R5", "read slot9 (R1 MSB first)", r, 8'h81);
    chk("R5", "sdo idle after read", {7'd0, sdo}, 8'h00);
    chk("R1", "pwr_down stays 0", {7'd0, pwr_down}, 8'h00);
  endtask

  task automatic t_single_byte;
    logic [7:0] r;
    frame(mk_cmd(1'b1, 4'd3, 1'b0, 1'b0), 8'h00, 8, r);
    chk("R2", "power down by single byte", {7'd0, pwr_down}, 8'h01);
    // data-follows clear with extra bits: no write
    frame(mk_cmd(1'b1, 4'd3, 1'b0, 1'b0) | 8'h01, 8'h00, 16, r);
    chk("R3", "slot3 unchanged by single-byte frame", slot(3), 8'hA5);
    chk("R2", "pwr_down still 1", {7'd0, pwr_down}, 8'h01);
  endtask

  task automatic t_power_down_access;
    logic [7:0] r;
    wr(1'b1, 4'd5, 8'h5A);
    chk("R7", "write while powered down", slot(5), 8'h5A);
    rd(1'b1, 4'd3, r);
    chk("R7", "slot3 kept through power-down", r, 8'hA5);
    rd(1'b0, 4'd5, r);
    chk("R2", "power up on read frame", {7'd0, pwr_down}, 8'h00);
    chk("R7", "slot5 kept after power-up", r, 8'h5A);
  endtask

  task automatic t_holes;
    logic [7:0] r;
    wr(1'b0, 4'd12, 8'hFF);
    wr(1'b0, 4'd13, 8'hEE);
    wr(1'b0, 4'd15, 8'hDD);
    chk("R6", "slot12", slot(12), 8'h00);
    chk("R6", "slot13", slot(13), 8'h00);
    chk("R6", "slot15", slot(15), 8'h00);
    rd(1'b0, 4'd15, r);
    chk("R6", "read slot15", r, 8'h00);
    chk("R6", "slot14 not hit", slot(14), 8'h00);
  endtask

  task automatic t_test_slot;
    logic [7:0] r;
    wr(1'b0, 4'd14, 8'h77);
    rd(1'b0, 4'd14, r);
    chk("R11", "read slot14", r, 8'h77);
    chk("R11", "slot14 port", slot(14), 8'h77);
  endtask

  task automatic t_abort;
    logic [7:0] r;
    frame(mk_cmd(1'b0, 4'd3, 1'b0, 1'b1), 8'h11, 12, r);
    chk("R10", "partial data byte discarded", slot(3), 8'hA5);
    frame(mk_cmd(1'b1, 4'd3, 1'b0, 1'b1), 8'h00, 5, r);
    chk("R10", "partial command keeps pwr_down", {7'd0, pwr_down}, 8'h00);
  endtask

  task automatic t_soft_clear;
    logic [7:0] r;
    wr(1'b0, 4'd10, 8'h7F);
    chk("R9", "slot10 plain write", slot(10), 8'h7F);
    chk("R9", "slot3 unaffected", slot(3), 8'hA5);
    wr(1'b1, 4'd10, 8'h80);
    chk("R9", "slot3 cleared", slot(3), 8'h00);
    chk("R9", "slot14 cleared", slot(14), 8'h00);
    chk("R9", "pwr_down kept", {7'd0, pwr_down}, 8'h01);
    rd(1'b1, 4'd10, r);
    chk("R9", "slot10 self-clears", r, 8'h00);
  endtask

  task automatic t_por;
    wr(1'b1, 4'd6, 8'hC3);
    chk("R4", "slot6 before POR", slot(6), 8'hC3);
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(3);
    chk("R8", "slot6 after POR", slot(6), 8'h00);
    chk("R8", "pwr_down after POR", {7'd0, pwr_down}, 8'h00);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_write_read();
    t_single_byte();
    t_power_down_access();
    t_holes();
    t_test_slot();
    t_abort();
    t_soft_clear();
    t_por();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule